// File: doc/BRIEF.md
# SPI Target Firmware-Mode Byte Exchange

This block is the firmware-mode data path of an SPI target. An SPI shifter hands it one strobe per completed byte. On each strobe the block returns the next byte to shift out, taken from a transmit queue, and stores the byte it received in a receive queue. Software fills the transmit queue with 32-bit word writes into an address window. Each word is split into four bytes, and a configuration bit selects the byte order. Software empties the receive queue through a pop handshake.

Both queues report depth-based events: threshold crossings, full, overflow and underflow. These events feed a 12-source interrupt block. The interrupt block has sticky state bits that software clears by writing ones, per-source enables, and a test register. A register interface also gives queue depths and status, flushes each queue, and pulses a fatal alert on request.

Top module: `spid_gen_xchg`

## Requirements
- R1: On a byte strobe with the TX queue non-empty, `spi_tx_byte_o` shows the queue head from the next cycle, in push order. With the TX queue empty, it shows 0x00 and interrupt state bit 5 (tx underflow) sets.
- R2: Every strobed byte that finds room is stored in the RX queue. Bytes leave the queue in arrival order on `rxq_data_o`, one per `rxq_pop_i` cycle. The head is visible without delay.
- R3: State bit 1 (rx watermark) sets when the RX depth after a push exceeds the RX level, LEVELS (0x18) bits 15:0. State bit 2 (tx watermark) sets when the TX depth after a pop is below the TX level, LEVELS bits 31:16.
- R4: A push that makes the RX queue hold DEPTH bytes sets state bit 0 (rx full). A byte arriving while the queue is full, with no pop in the same cycle, is dropped, sets state bit 4 (rx overflow), and leaves the queue contents unchanged.
- R5: A word write to any address with bit 11 set pushes four bytes into the TX queue. CONFIG (0x14) bit 2 selects the order: when it is 1, bits 7:0 go first; when it is 0, bits 31:24 go first. Bytes beyond the free space are dropped.
- R6: Writing 1 to a bit of INTR_STATE (0x00) clears that bit. An event raised in the same cycle wins, so the bit stays set.
- R7: `intr_o` is INTR_STATE ANDed with INTR_ENABLE (0x04). Writing 1 to a bit of INTR_TEST (0x08) sets that state bit. State bits 31:12 always read 0.
- R8: In CONTROL (0x10), the mode field in bits 5:4 always reads 0, whatever value is written. Writing 1 to bit 16 empties the TX queue, and writing 1 to bit 17 empties the RX queue.
- R9: LEVELS resets to 0x0000_0080. DEPTHS (0x1C) gives the RX depth in bits 7:0 and the TX depth in bits 23:16. STATUS (0x20) bits 0 to 3 are rx full, rx empty, tx full and tx empty, and STATUS resets to 0xA.
- R10: Writing 1 to bit 0 of ALERT_TEST (0x0C) makes `alert_o` high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_byte_valid_i | input | 1 | One-cycle strobe per completed SPI byte |
| spi_rx_byte_i | input | 8 | Byte received from the host |
| spi_tx_byte_o | output | 8 | Byte to shift out next |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| rxq_pop_i | input | 1 | Remove the RX queue head |
| rxq_data_o | output | 8 | RX queue head |
| rxq_empty_o | output | 1 | RX queue holds no byte |
| intr_o | output | 12 | Enabled interrupt lines |
| alert_o | output | 1 | Fatal alert pulse |

## Verification
The properties assume that a byte strobe never arrives in the same cycle as a register write when they check queue depth and the full and overflow events, because a flush in that cycle would change the outcome. The stimulus separates strobes from register writes in every case except one: a single deliberate overlap of a strobe with an INTR_STATE clear, which is there to exercise the event-over-clear priority. The bench also never pops an empty queue and never sends a strobe on two consecutive cycles.

// File: rtl/spid_pkg.sv
`timescale 1ns/1ps
package spid_pkg;
   localparam int NUM_IRQ  = 12;
   localparam int LEVEL_W  = 16;

   // interrupt source positions
   localparam int IRQ_RX_FULL  = 0;
   localparam int IRQ_RX_WMARK = 1;
   localparam int IRQ_TX_WMARK = 2;
   localparam int IRQ_RX_OVF   = 4;
   localparam int IRQ_TX_UDF   = 5;

   typedef logic [NUM_IRQ-1:0] irq_vec_t;

   // word index of a control register (address bits 5:2)
   typedef enum logic [3:0] {
      RI_ISTATE = 4'd0,
      RI_IEN    = 4'd1,
      RI_ITEST  = 4'd2,
      RI_ALERT  = 4'd3,
      RI_CTRL   = 4'd4,
      RI_CFG    = 4'd5,
      RI_LEVEL  = 4'd6,
      RI_DEPTH  = 4'd7,
      RI_STAT   = 4'd8
   } reg_idx_e;
endpackage

// File: rtl/spid_fifo.sv
`timescale 1ns/1ps
module spid_fifo #(
   parameter int DEPTH   = 16,
   parameter int MAXPUSH = 1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1,
   localparam int PW = $clog2(MAXPUSH + 1)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clr_i,
   input  logic [PW-1:0]        push_cnt_i,
   input  logic [8*MAXPUSH-1:0] push_data_i,
   input  logic                 pop_i,
   output logic [7:0]           head_o,
   output logic [CW-1:0]        count_o,
   output logic                 full_o,
   output logic                 empty_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spid_fifo: DEPTH must be a power of two >= 2");
   end
   if (MAXPUSH < 1 || MAXPUSH > DEPTH) begin : g_bad_push
      $error("spid_fifo: MAXPUSH must lie in 1..DEPTH");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt, room, accept;
   logic          pop_ok;

   assign pop_ok = pop_i && (cnt != '0);
   // space seen by this cycle's pushes counts a simultaneous pop
   assign room   = CW'(DEPTH) - cnt + CW'(pop_ok);
   assign accept = (CW'(push_cnt_i) > room) ? room : CW'(push_cnt_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr_i) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         wptr <= wptr + AW'(accept);
         rptr <= rptr + AW'(pop_ok);
         cnt  <= cnt + accept - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk_i) begin
      for (int k = 0; k < MAXPUSH; k++) begin
         if (!clr_i && (k < int'(accept))) begin
            mem[wptr + AW'(k)] <= push_data_i[8*k +: 8];
         end
      end
   end

   assign head_o  = mem[rptr];
   assign count_o = cnt;
   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
endmodule

// File: rtl/spid_irq.sv
`timescale 1ns/1ps
module spid_irq #(
   parameter int N = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] event_i,
   input  logic [N-1:0] clear_i,
   input  logic [N-1:0] force_i,
   input  logic         en_we_i,
   input  logic [N-1:0] en_wdata_i,
   output logic [N-1:0] state_o,
   output logic [N-1:0] enable_o,
   output logic [N-1:0] intr_o
);
   logic [N-1:0] state_q, enable_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= '0;
         enable_q <= '0;
      end else begin
         // hardware events and forced bits override a software clear
         state_q <= (state_q & ~clear_i) | event_i | force_i;
         if (en_we_i) enable_q <= en_wdata_i;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign intr_o[i] = state_q[i] & enable_q[i];
   end

   assign state_o  = state_q;
   assign enable_o = enable_q;
endmodule

// File: rtl/spid_gen_xchg.sv
`timescale 1ns/1ps
module spid_gen_xchg
   import spid_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 12,
   localparam int CW     = $clog2(DEPTH) + 1,
   localparam int WIN_BIT = ADDR_W - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              spi_byte_valid_i,
   input  logic [7:0]        spi_rx_byte_i,
   output logic [7:0]        spi_tx_byte_o,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   input  logic              rxq_pop_i,
   output logic [7:0]        rxq_data_o,
   output logic              rxq_empty_o,
   output logic [11:0]       intr_o,
   output logic              alert_o
);
   if (DEPTH > 128) begin : g_bad_depth
      $error("spid_gen_xchg: DEPTH must fit the 8-bit depth fields");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("spid_gen_xchg: ADDR_W too small for the register map");
   end

   // ---------------- register decode ----------------
   logic     win_sel, csr_ok, csr_we, win_we;
   reg_idx_e ridx;

   assign win_sel = reg_addr_i[WIN_BIT];
   assign csr_ok  = !win_sel && (reg_addr_i[WIN_BIT-1:6] == '0) && (reg_addr_i[1:0] == 2'b00);
   assign ridx    = reg_idx_e'(reg_addr_i[5:2]);
   assign csr_we  = reg_we_i && csr_ok;
   assign win_we  = reg_we_i && win_sel;

   logic               cfg_lsb_first;
   logic [LEVEL_W-1:0] rx_level, tx_level;
   logic               alert_q;
   logic               tx_clr, rx_clr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_lsb_first <= 1'b0;
         rx_level      <= LEVEL_W'(16'h0080);
         tx_level      <= '0;
         alert_q       <= 1'b0;
      end else begin
         alert_q <= csr_we && (ridx == RI_ALERT) && reg_wdata_i[0];
         if (csr_we && ridx == RI_CFG)   cfg_lsb_first <= reg_wdata_i[2];
         if (csr_we && ridx == RI_LEVEL) {tx_level, rx_level} <= reg_wdata_i;
      end
   end

   assign alert_o = alert_q;
   assign tx_clr  = csr_we && (ridx == RI_CTRL) && reg_wdata_i[16];
   assign rx_clr  = csr_we && (ridx == RI_CTRL) && reg_wdata_i[17];

   // ---------------- TX queue ----------------
   logic [31:0]   tx_bytes;
   logic [7:0]    tx_head;
   logic [CW-1:0] tx_cnt;
   logic          tx_full, tx_empty, tx_pop;

   for (genvar b = 0; b < 4; b++) begin : g_split
      assign tx_bytes[8*b +: 8] = cfg_lsb_first ? reg_wdata_i[8*b +: 8]
                                                : reg_wdata_i[8*(3-b) +: 8];
   end

   assign tx_pop = spi_byte_valid_i && !tx_empty;

   spid_fifo #(.DEPTH(DEPTH), .MAXPUSH(4)) u_txq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (tx_clr),
      .push_cnt_i  (win_we ? 3'd4 : 3'd0),
      .push_data_i (tx_bytes),
      .pop_i       (tx_pop),
      .head_o      (tx_head),
      .count_o     (tx_cnt),
      .full_o      (tx_full),
      .empty_o     (tx_empty)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               spi_tx_byte_o <= 8'h00;
      else if (spi_byte_valid_i) spi_tx_byte_o <= tx_empty ? 8'h00 : tx_head;
   end

   // ---------------- RX queue ----------------
   logic [CW-1:0] rx_cnt, rx_next;
   logic          rx_full, rx_empty, rx_pop_eff, rx_room, rx_ok;

   assign rx_pop_eff = rxq_pop_i && !rx_empty;
   assign rx_room    = !rx_full || rx_pop_eff;
   assign rx_ok      = spi_byte_valid_i && rx_room;
   assign rx_next    = rx_cnt + CW'(rx_ok) - CW'(rx_pop_eff);

   spid_fifo #(.DEPTH(DEPTH), .MAXPUSH(1)) u_rxq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (rx_clr),
      .push_cnt_i  (spi_byte_valid_i),
      .push_data_i (spi_rx_byte_i),
      .pop_i       (rxq_pop_i),
      .head_o      (rxq_data_o),
      .count_o     (rx_cnt),
      .full_o      (rx_full),
      .empty_o     (rx_empty)
   );

   assign rxq_empty_o = rx_empty;

   // ---------------- events and interrupts ----------------
   irq_vec_t events, irq_state, irq_en;

   always_comb begin
      events = '0;
      events[IRQ_RX_FULL]  = rx_ok && (rx_next == CW'(DEPTH));
      events[IRQ_RX_WMARK] = rx_ok && (32'(rx_next) > 32'(rx_level));
      events[IRQ_TX_WMARK] = tx_pop && ((32'(tx_cnt) - 32'd1) < 32'(tx_level));
      events[IRQ_RX_OVF]   = spi_byte_valid_i && !rx_room;
      events[IRQ_TX_UDF]   = spi_byte_valid_i && tx_empty;
   end

   spid_irq #(.N(NUM_IRQ)) u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .event_i    (events),
      .clear_i    ((csr_we && ridx == RI_ISTATE) ? reg_wdata_i[NUM_IRQ-1:0] : '0),
      .force_i    ((csr_we && ridx == RI_ITEST)  ? reg_wdata_i[NUM_IRQ-1:0] : '0),
      .en_we_i    (csr_we && ridx == RI_IEN),
      .en_wdata_i (reg_wdata_i[NUM_IRQ-1:0]),
      .state_o    (irq_state),
      .enable_o   (irq_en),
      .intr_o     (intr_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata_o = '0;
      if (csr_ok) begin
         case (ridx)
            RI_ISTATE: reg_rdata_o = 32'(irq_state);
            RI_IEN:    reg_rdata_o = 32'(irq_en);
            RI_CFG:    reg_rdata_o = 32'({cfg_lsb_first, 2'b00});
            RI_LEVEL:  reg_rdata_o = {tx_level, rx_level};
            RI_DEPTH:  reg_rdata_o = {8'h00, 8'(tx_cnt), 8'h00, 8'(rx_cnt)};
            RI_STAT:   reg_rdata_o = {28'h0, tx_empty, tx_full, rx_empty, rx_full};
            default:   reg_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/spid_gen_xchg_chk.sv
`timescale 1ns/1ps
module spid_gen_xchg_chk #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 12,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              spi_byte_valid_i,
   input logic              rxq_pop_i,
   input logic [7:0]        spi_tx_byte_o,
   input logic              alert_o,
   input logic              reg_we_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [31:0]       reg_wdata_i,
   input logic [11:0]       irq_state,
   input logic [CW-1:0]     rx_cnt,
   input logic [CW-1:0]     tx_cnt
);
   // R1
   tx_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_byte_valid_i && tx_cnt == '0 |=> spi_tx_byte_o == 8'h00 && irq_state[5]);

   // R2
   rx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_byte_valid_i && rx_cnt < CW'(DEPTH) && !rxq_pop_i && !reg_we_i
      |=> rx_cnt == CW'($past(rx_cnt) + 1'b1));

   // R4
   rx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_byte_valid_i && rx_cnt == CW'(DEPTH - 1) && !rxq_pop_i && !reg_we_i
      |=> irq_state[0]);

   // R4
   rx_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_byte_valid_i && rx_cnt == CW'(DEPTH) && !rxq_pop_i && !reg_we_i
      |=> irq_state[4] && rx_cnt == CW'(DEPTH));

   // R10
   alert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alert_o |-> $past(reg_we_i && !reg_addr_i[ADDR_W-1] && reg_addr_i[5:2] == 4'd3
                        && reg_wdata_i[0]));
endmodule

bind spid_gen_xchg spid_gen_xchg_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .spi_byte_valid_i (spi_byte_valid_i),
   .rxq_pop_i        (rxq_pop_i),
   .spi_tx_byte_o    (spi_tx_byte_o),
   .alert_o          (alert_o),
   .reg_we_i         (reg_we_i),
   .reg_addr_i       (reg_addr_i),
   .reg_wdata_i      (reg_wdata_i),
   .irq_state        (irq_state),
   .rx_cnt           (rx_cnt),
   .tx_cnt           (tx_cnt)
);

// File: tb/spid_gen_xchg_bench.sv
`timescale 1ns/1ps
module spid_gen_xchg_bench;
   localparam int DEPTH = 16;
   localparam logic [11:0] A_ISTATE = 12'h000, A_IEN = 12'h004, A_ITEST = 12'h008,
                           A_ALERT = 12'h00C, A_CTRL = 12'h010, A_CFG = 12'h014,
                           A_LEVEL = 12'h018, A_DEPTH = 12'h01C, A_STAT = 12'h020,
                           A_WIN = 12'h800;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        spi_valid = 1'b0, reg_we = 1'b0, rxq_pop = 1'b0;
   logic [7:0]  spi_byte = '0, tx_byte, rxq_data;
   logic [11:0] reg_addr = '0, intr;
   logic [31:0] reg_wdata = '0, reg_rdata, v;
   logic        rxq_empty, alert;

   always #2.5 clk = ~clk;

   spid_gen_xchg u_spid_gen_xchg (
      .clk_i (clk), .rst_ni (rst_n),
      .spi_byte_valid_i (spi_valid), .spi_rx_byte_i (spi_byte), .spi_tx_byte_o (tx_byte),
      .reg_we_i (reg_we), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
      .rxq_pop_i (rxq_pop), .rxq_data_o (rxq_data), .rxq_empty_o (rxq_empty),
      .intr_o (intr), .alert_o (alert)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] txm[$], rxm[$], exp_q[$];
   logic mon_pend = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compare each returned byte with the queued expectation
   always @(posedge clk) mon_pend <= spi_valid;
   always @(negedge clk) begin
      if (mon_pend) begin
         if (exp_q.size() > 0) check("R1 tx byte", 32'(tx_byte), 32'(exp_q.pop_front()));
         else check("R1 unexpected strobe", 32'(tx_byte), 32'hFFFF_FFFF);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic expect_strobe(input logic [7:0] b);
      exp_q.push_back((txm.size() > 0) ? txm.pop_front() : 8'h00);
      if (rxm.size() < DEPTH) rxm.push_back(b);
   endtask

   task automatic spi(input logic [7:0] b);
      @(negedge clk); spi_valid = 1'b1; spi_byte = b; expect_strobe(b);
      @(negedge clk); spi_valid = 1'b0;
   endtask

   task automatic tx_word(input logic [31:0] w, input bit lsb);
      for (int k = 0; k < 4; k++) begin
         if (txm.size() < DEPTH) txm.push_back(lsb ? w[8*k +: 8] : w[8*(3-k) +: 8]);
      end
      wr(A_WIN, w);
   endtask

   task automatic drain(input string req);
      @(negedge clk);
      check(req, 32'(rxq_data), 32'(rxm.pop_front()));
      rxq_pop = 1'b1;
      @(negedge clk); rxq_pop = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset values
      rd(A_STAT, v);   check("R9 status reset", v, 32'hA);
      rd(A_LEVEL, v);  check("R9 levels reset", v, 32'h0000_0080);
      rd(A_ISTATE, v); check("R6 state reset", v, 32'h0);
      check("R10 alert idle", 32'(alert), 32'h0);
      wr(A_IEN, 32'hFFF);
      rd(A_IEN, v);    check("R7 enable readback", v, 32'hFFF);

      // R5 LSB-first word, R1 ordered return
      wr(A_CFG, 32'h4);
      tx_word(32'h4433_2211, 1'b1);
      for (int i = 0; i < 4; i++) spi(8'hA0 + 8'(i));
      spi(8'hA4);                       // TX now empty: underflow
      rd(A_ISTATE, v); check("R1 underflow state", v, 32'h20);
      check("R7 intr line follows state", 32'(intr), 32'h20);
      wr(A_ISTATE, 32'h20);
      rd(A_ISTATE, v); check("R6 write-one clears", v, 32'h0);

      // R5 MSB-first word, R9 depths
      wr(A_CFG, 32'h0);
      tx_word(32'h5566_7788, 1'b0);
      rd(A_DEPTH, v);  check("R9 depth readback", v, 32'h0004_0005);
      for (int i = 0; i < 5; i++) drain("R2 rx order");

      // R3 TX watermark with TX level 3
      wr(A_LEVEL, 32'h0003_0080);
      spi(8'hB0);
      rd(A_ISTATE, v); check("R3 tx wmark not yet", v & 32'h4, 32'h0);
      spi(8'hB1);
      rd(A_ISTATE, v); check("R3 tx wmark set", v & 32'h4, 32'h4);
      wr(A_ISTATE, 32'hFFF);

      // R3 RX watermark with RX level 2
      wr(A_LEVEL, 32'h0000_0002);
      drain("R2 rx order"); drain("R2 rx order");
      spi(8'hC0); spi(8'hC1);
      rd(A_ISTATE, v); check("R3 rx wmark not yet", v & 32'h2, 32'h0);
      spi(8'hC2);
      rd(A_ISTATE, v); check("R3 rx wmark set", v & 32'h2, 32'h2);
      wr(A_ISTATE, 32'hFFF);

      // R4 full then overflow
      for (int i = 0; i < 13; i++) spi(8'hD0 + 8'(i));
      rd(A_ISTATE, v); check("R4 full without overflow", v & 32'h11, 32'h01);
      spi(8'hEE);
      rd(A_ISTATE, v); check("R4 overflow set", v & 32'h10, 32'h10);
      rd(A_DEPTH, v);  check("R4 depth held at full", v & 32'hFF, 32'd16);
      rd(A_STAT, v);   check("R9 rx full flag", v & 32'h1, 32'h1);
      for (int i = 0; i < 16; i++) drain("R4 contents kept");
      wr(A_ISTATE, 32'hFFF);

      // R6 event beats clear in the same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_ISTATE; reg_wdata = 32'h20;
      spi_valid = 1'b1; spi_byte = 8'hF0; expect_strobe(8'hF0);
      @(negedge clk); reg_we = 1'b0; spi_valid = 1'b0;
      rd(A_ISTATE, v); check("R6 event wins over clear", v & 32'h20, 32'h20);

      // R7 test register and enable mask
      wr(A_ITEST, 32'h800);
      rd(A_ISTATE, v); check("R7 test sets state", v & 32'h800, 32'h800);
      check("R7 intr for tested bit", 32'(intr[11]), 32'h1);
      wr(A_ITEST, 32'hFFFF_F000);
      rd(A_ISTATE, v); check("R7 reserved bits zero", v >> 12, 32'h0);
      wr(A_IEN, 32'h0);
      check("R7 masked lines low", 32'(intr), 32'h0);

      // R8 mode forced, queue flushes
      wr(A_CTRL, 32'h20);
      rd(A_CTRL, v);   check("R8 mode reads zero", (v >> 4) & 32'h3, 32'h0);
      tx_word(32'h0102_0304, 1'b0);
      wr(A_CTRL, 32'h0003_0000);
      txm.delete(); rxm.delete();
      rd(A_STAT, v);   check("R8 flush empties both", v, 32'hA);
      rd(A_DEPTH, v);  check("R8 depths after flush", v, 32'h0);

      // R10 alert pulse
      wr(A_ALERT, 32'h1);
      check("R10 alert high", 32'(alert), 32'h1);
      @(negedge clk);
      check("R10 alert single cycle", 32'(alert), 32'h0);

      // R5 overfill the TX queue; extra word dropped
      wr(A_CFG, 32'h4);
      for (int k = 0; k < 5; k++)
         tx_word({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, 1'b1);
      rd(A_DEPTH, v);  check("R5 tx depth capped", (v >> 16) & 32'hFF, 32'd16);
      rd(A_STAT, v);   check("R9 tx full flag", v & 32'h4, 32'h4);
      for (int i = 0; i < 17; i++) spi(8'h30 + 8'(i));

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule